// File: doc/BRIEF.md
# Programmable Disk Port Cycle Timer

This block times a single access to a disk drive's data port or command/control port, counting in bus clocks. A start pulse launches a cycle of three phases that always run in the same order: an address setup phase, an active phase during which the read or write strobe is driven, and a hold phase. One clock after the last hold clock the block raises a one-clock completion pulse.

Each phase length comes from a packed 8-bit timing byte. The block keeps two such bytes, one for data-port cycles and one for command/control cycles, and a select input chooses which byte governs the next cycle. Both bytes can be rewritten through a simple write port, and their current values are visible on outputs. The selected byte is captured when a cycle starts, so a rewrite during a cycle has no effect on that cycle. When ready handling is enabled, the drive can hold the active phase open by keeping its ready line low.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset the data-port timing byte reads 0xF5, the command-port timing byte reads 0xDE, and busy, done, rdStrobe and wrStrobe are all low.
- R2: Bits 7..6 of the governing timing byte set the setup phase: code n gives n+1 clocks with busy high and both strobes low before the strobe rises.
- R3: Bits 2..0 of the governing timing byte set the active phase: code n gives n+2 clocks of strobe when ready handling is disabled or the ready line is high.
- R4: Bits 5..3 of the governing timing byte set the hold phase: code n gives n+1 clocks with busy high and strobes low after the strobe falls; done is then high for exactly one clock, with busy low.
- R5: portSel low at the accepted start selects the data-port byte; portSel high selects the command-port byte.
- R6: isWrite high at the accepted start makes the active phase drive wrStrobe; low drives rdStrobe. The two strobes are never high together and neither is high outside the active phase.
- R7: With waitEnable high, the active phase does not end while iordyIn is low at its final clock; it ends on the first clock edge at which iordyIn is high and the minimum active time has elapsed.
- R8: With waitEnable low, iordyIn has no effect on the active length.
- R9: A start request while busy is high is ignored: no second cycle follows the running one.
- R10: timingWrEn writes timingWrData into the data-port byte (timingWrSel low) or the command-port byte (timingWrSel high) on the next clock edge; a write during a cycle does not change the cycle already running but governs the next one.
- R11: busy goes high only on the clock edge that accepts a start request and stays high until the last hold clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a port access cycle |
| portSel | input | 1 | 0 = data-port timing, 1 = command-port timing |
| isWrite | input | 1 | 1 = write access, 0 = read access |
| waitEnable | input | 1 | Enables active-phase stretching by the ready line |
| iordyIn | input | 1 | Drive ready line, low requests extension |
| timingWrEn | input | 1 | Write strobe for a timing byte |
| timingWrSel | input | 1 | 0 = write data-port byte, 1 = write command-port byte |
| timingWrData | input | 8 | New timing byte value |
| dataTiming | output | 8 | Current data-port timing byte |
| cmdTiming | output | 8 | Current command-port timing byte |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse after the hold phase |
| rdStrobe | output | 1 | Read strobe, high during the active phase of a read |
| wrStrobe | output | 1 | Write strobe, high during the active phase of a write |

## Verification
Cycles run first with the reset-value bytes on both ports, then with random timing bytes, random port selection and random direction, so that swapped setup and hold fields or an off-by-one in any field offset give a measured phase length that differs from the expected one. Ready-line release points both before and after the minimum active time separate a correct stretch from one that adds or loses a clock, and the same release pattern with handling disabled shows the line being ignored. Directed cycles poke a second start and a timing-byte rewrite into a running cycle, which distinguishes a captured timing byte from a live one and a guarded start from a restart.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int TIMING_W = 8;
  localparam int CNT_W    = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD,
    PH_DONE
  } phase_t;

  typedef enum logic [2:0] {
    CNT_KEEP,
    CNT_SETUP,
    CNT_ACTIVE,
    CNT_HOLD,
    CNT_DEC
  } cntOp_t;

  typedef struct packed {
    logic   snapEn;
    cntOp_t cntOp;
  } ctrlStrobe_t;

  // Counter preloads: a phase of L clocks loads L-1 and counts down to zero.
  function automatic logic [CNT_W-1:0] setupLoad(input logic [TIMING_W-1:0] b);
    return {{(CNT_W-2){1'b0}}, b[7:6]};
  endfunction

  function automatic logic [CNT_W-1:0] holdLoad(input logic [TIMING_W-1:0] b);
    return {{(CNT_W-3){1'b0}}, b[5:3]};
  endfunction

  function automatic logic [CNT_W-1:0] activeLoad(input logic [TIMING_W-1:0] b);
    return {{(CNT_W-3){1'b0}}, b[2:0]} + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/pio_timer_datapath.sv
module pio_timer_datapath
  import pio_timer_pkg::*;
#(
  parameter logic [TIMING_W-1:0] DATA_RESET = 8'hF5,
  parameter logic [TIMING_W-1:0] CMD_RESET  = 8'hDE,
  parameter int                  NUM_PORTS  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                portSel,
  input  logic                timingWrEn,
  input  logic                timingWrSel,
  input  logic [TIMING_W-1:0] timingWrData,
  output logic [TIMING_W-1:0] dataTiming,
  output logic [TIMING_W-1:0] cmdTiming,
  output logic                countZero
);

  logic [TIMING_W-1:0] timingQ [NUM_PORTS];
  logic [TIMING_W-1:0] liveByte;
  logic [TIMING_W-1:0] snapQ;
  logic [CNT_W-1:0]    countQ;

  // One register per port, each with its own reset value.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_timing
    localparam logic [TIMING_W-1:0] RST_VAL = (g == 0) ? DATA_RESET : CMD_RESET;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        timingQ[g] <= RST_VAL;
      end else if (timingWrEn && (timingWrSel == 1'(g))) begin
        timingQ[g] <= timingWrData;
      end
    end
  end

  assign dataTiming = timingQ[0];
  assign cmdTiming  = timingQ[1];
  assign liveByte   = timingQ[portSel];

  // Snapshot of the governing byte, taken when a cycle is accepted.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapQ <= '0;
    end else if (strobe.snapEn) begin
      snapQ <= liveByte;
    end
  end

  // Phase counter. The setup preload reads the live byte, because the
  // snapshot is written on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else begin
      unique case (strobe.cntOp)
        CNT_SETUP:  countQ <= setupLoad(liveByte);
        CNT_ACTIVE: countQ <= activeLoad(snapQ);
        CNT_HOLD:   countQ <= holdLoad(snapQ);
        CNT_DEC:    countQ <= countQ - {{(CNT_W-1){1'b0}}, 1'b1};
        default:    countQ <= countQ;
      endcase
    end
  end

  assign countZero = (countQ == '0);

endmodule

// File: rtl/pio_timer_ctrl.sv
module pio_timer_ctrl
  import pio_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        isWrite,
  input  logic        waitEnable,
  input  logic        iordyIn,
  input  logic        countZero,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        rdStrobe,
  output logic        wrStrobe
);

  phase_t phaseQ, phaseD;
  logic   dirWriteQ;
  logic   acceptStart;
  logic   activeRelease;

  // A new cycle may begin only when nothing is running.
  assign acceptStart   = startReq && (phaseQ == PH_IDLE || phaseQ == PH_DONE);
  assign activeRelease = countZero && (!waitEnable || iordyIn);

  always_comb begin
    phaseD       = phaseQ;
    strobe       = '{snapEn: 1'b0, cntOp: CNT_KEEP};
    unique case (phaseQ)
      PH_IDLE, PH_DONE: begin
        if (acceptStart) begin
          phaseD       = PH_SETUP;
          strobe.snapEn = 1'b1;
          strobe.cntOp  = CNT_SETUP;
        end else begin
          phaseD = PH_IDLE;
        end
      end
      PH_SETUP: begin
        if (countZero) begin
          phaseD       = PH_ACTIVE;
          strobe.cntOp = CNT_ACTIVE;
        end else begin
          strobe.cntOp = CNT_DEC;
        end
      end
      PH_ACTIVE: begin
        if (activeRelease) begin
          phaseD       = PH_HOLD;
          strobe.cntOp = CNT_HOLD;
        end else if (!countZero) begin
          strobe.cntOp = CNT_DEC;
        end
      end
      PH_HOLD: begin
        if (countZero) begin
          phaseD = PH_DONE;
        end else begin
          strobe.cntOp = CNT_DEC;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ    <= PH_IDLE;
      dirWriteQ <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      if (acceptStart) begin
        dirWriteQ <= isWrite;
      end
    end
  end

  assign busy     = (phaseQ == PH_SETUP) || (phaseQ == PH_ACTIVE) || (phaseQ == PH_HOLD);
  assign done     = (phaseQ == PH_DONE);
  assign rdStrobe = (phaseQ == PH_ACTIVE) && !dirWriteQ;
  assign wrStrobe = (phaseQ == PH_ACTIVE) &&  dirWriteQ;

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter logic [TIMING_W-1:0] DATA_RESET = 8'hF5,
  parameter logic [TIMING_W-1:0] CMD_RESET  = 8'hDE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                portSel,
  input  logic                isWrite,
  input  logic                waitEnable,
  input  logic                iordyIn,
  input  logic                timingWrEn,
  input  logic                timingWrSel,
  input  logic [TIMING_W-1:0] timingWrData,
  output logic [TIMING_W-1:0] dataTiming,
  output logic [TIMING_W-1:0] cmdTiming,
  output logic                busy,
  output logic                done,
  output logic                rdStrobe,
  output logic                wrStrobe
);

  ctrlStrobe_t ctrlStrobe;
  logic        countZero;

  pio_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .isWrite    (isWrite),
    .waitEnable (waitEnable),
    .iordyIn    (iordyIn),
    .countZero  (countZero),
    .strobe     (ctrlStrobe),
    .busy       (busy),
    .done       (done),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe)
  );

  pio_timer_datapath #(
    .DATA_RESET (DATA_RESET),
    .CMD_RESET  (CMD_RESET)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (ctrlStrobe),
    .portSel      (portSel),
    .timingWrEn   (timingWrEn),
    .timingWrSel  (timingWrSel),
    .timingWrData (timingWrData),
    .dataTiming   (dataTiming),
    .cmdTiming    (cmdTiming),
    .countZero    (countZero)
  );

endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       timingWrEn,
  input logic [7:0] dataTiming,
  input logic [7:0] cmdTiming,
  input logic       busy,
  input logic       done,
  input logic       rdStrobe,
  input logic       wrStrobe
);

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  // R6
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) |-> busy);

  // R3
  strobe_min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe || wrStrobe) |=> (rdStrobe || wrStrobe));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  // R10
  timing_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timingWrEn |=> ($stable(dataTiming) && $stable(cmdTiming)));

endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .timingWrEn (timingWrEn),
  .dataTiming (dataTiming),
  .cmdTiming  (cmdTiming),
  .busy       (busy),
  .done       (done),
  .rdStrobe   (rdStrobe),
  .wrStrobe   (wrStrobe)
);

// File: tb/pio_cycle_timer_tb.sv
module pio_cycle_timer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       portSel = 1'b0;
  logic       isWrite = 1'b0;
  logic       waitEnable = 1'b0;
  logic       iordyIn = 1'b1;
  logic       timingWrEn = 1'b0;
  logic       timingWrSel = 1'b0;
  logic [7:0] timingWrData = 8'h00;
  logic [7:0] dataTiming, cmdTiming;
  logic       busy, done, rdStrobe, wrStrobe;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;
  logic [7:0] modelByte [2];

  always #10 clk = ~clk;

  pio_cycle_timer u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .portSel(portSel),
    .isWrite(isWrite), .waitEnable(waitEnable), .iordyIn(iordyIn),
    .timingWrEn(timingWrEn), .timingWrSel(timingWrSel), .timingWrData(timingWrData),
    .dataTiming(dataTiming), .cmdTiming(cmdTiming), .busy(busy), .done(done),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe)
  );

  function automatic int expSetup(input logic [7:0] b);  return int'(b[7:6]) + 1; endfunction
  function automatic int expHold(input logic [7:0] b);   return int'(b[5:3]) + 1; endfunction
  function automatic int expActive(input logic [7:0] b, input logic wEn, input int k);
    int base = int'(b[2:0]) + 2;
    if (wEn && k > base) return k;
    return base;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeTiming(input logic sel, input logic [7:0] val);
    @(negedge clk);
    timingWrEn = 1'b1; timingWrSel = sel; timingWrData = val;
    @(negedge clk);
    timingWrEn = 1'b0;
    modelByte[sel] = val;
  endtask

  // Runs one cycle and compares each phase length with the model.
  // k: ready released after k strobe clocks (0 = high throughout).
  task automatic runCycle(input logic sel, input logic wr, input logic wEn, input int k,
                          input bit pokeStart, input bit midWrite, input logic [7:0] midVal);
    logic [7:0] gov;
    int s, a, h, guard;
    bit dirOk, pokeWr, pokeSt, seenStrobe;
    gov = modelByte[sel];
    s = 0; a = 0; h = 0; guard = 0; dirOk = 1; pokeWr = 0; pokeSt = 0; seenStrobe = 0;
    @(negedge clk);
    startReq = 1'b1; portSel = sel; isWrite = wr; waitEnable = wEn;
    iordyIn = (k > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R11 busy after start", int'(busy), 1);
    while (!done && guard < 200) begin
      if (pokeWr) begin timingWrEn = 1'b0; pokeWr = 0; modelByte[sel] = midVal; end
      if (pokeSt) begin startReq = 1'b0; pokeSt = 0; end
      if (rdStrobe || wrStrobe) begin
        seenStrobe = 1;
        a++;
        if ((rdStrobe && wr) || (wrStrobe && !wr) || (rdStrobe && wrStrobe)) dirOk = 0;
        if (a == k) iordyIn = 1'b1;
        if (pokeStart && a == 1) begin startReq = 1'b1; pokeSt = 1; end
      end else if (busy && !seenStrobe) begin
        s++;
        if (midWrite && s == 1) begin
          timingWrEn = 1'b1; timingWrSel = sel; timingWrData = midVal; pokeWr = 1;
        end
      end else if (busy) begin
        h++;
      end
      guard++;
      @(negedge clk);
    end
    if (pokeWr) begin timingWrEn = 1'b0; modelByte[sel] = midVal; end
    startReq = 1'b0;
    check(s == expSetup(gov), "R2/R5 setup length", s, expSetup(gov));
    check(a == expActive(gov, wEn, k), wEn ? "R7 active length" : "R3/R8 active length",
          a, expActive(gov, wEn, k));
    check(h == expHold(gov), "R4 hold length", h, expHold(gov));
    check(dirOk, "R6 strobe direction", int'(dirOk), 1);
    check(done && !busy, "R4 done with busy low", int'({done, busy}), 2);
    @(negedge clk);
    check(!done, "R4 done one clock", int'(done), 0);
    check(!busy, "R9 no second cycle", int'(busy), 0);
    iordyIn = 1'b1;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) cycleCount++;

  initial begin
    void'($urandom(32'h5EED_1234));
    modelByte[0] = 8'hF5;
    modelByte[1] = 8'hDE;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dataTiming == 8'hF5, "R1 data byte reset", int'(dataTiming), 8'hF5);
    check(cmdTiming == 8'hDE, "R1 cmd byte reset", int'(cmdTiming), 8'hDE);
    check(!busy && !done && !rdStrobe && !wrStrobe, "R1 outputs idle",
          int'({busy, done, rdStrobe, wrStrobe}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 reset-value bytes on each port, both directions
    runCycle(1'b0, 1'b0, 1'b0, 0, 0, 0, 8'h00);
    runCycle(1'b1, 1'b1, 1'b0, 0, 0, 0, 8'h00);

    // R10 write port
    writeTiming(1'b0, 8'h00);
    check(dataTiming == 8'h00, "R10 data byte write", int'(dataTiming), 0);
    check(cmdTiming == 8'hDE, "R10 cmd byte untouched", int'(cmdTiming), 8'hDE);
    runCycle(1'b0, 1'b1, 1'b0, 0, 0, 0, 8'h00);
    writeTiming(1'b1, 8'hFF);
    check(cmdTiming == 8'hFF, "R10 cmd byte write", int'(cmdTiming), 8'hFF);
    runCycle(1'b1, 1'b0, 1'b0, 0, 0, 0, 8'h00);

    // R7 ready stretch, release after and before the minimum
    writeTiming(1'b0, 8'h4A);
    runCycle(1'b0, 1'b0, 1'b1, 9, 0, 0, 8'h00);
    runCycle(1'b0, 1'b1, 1'b1, 2, 0, 0, 8'h00);
    // R8 ready ignored when disabled
    runCycle(1'b0, 1'b0, 1'b0, 9, 0, 0, 8'h00);

    // R9 start during active ignored
    runCycle(1'b1, 1'b1, 1'b0, 0, 1, 0, 8'h00);

    // R10 mid-cycle rewrite, then the new byte governs the next cycle
    runCycle(1'b0, 1'b0, 1'b0, 0, 0, 1, 8'hC7);
    check(dataTiming == 8'hC7, "R10 mid-cycle write landed", int'(dataTiming), 8'hC7);
    runCycle(1'b0, 1'b1, 1'b0, 0, 0, 0, 8'h00);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic sel, wr, wEn;
      int k;
      if ($urandom_range(0, 1) == 1) writeTiming(1'($urandom_range(0, 1)), 8'($urandom()));
      sel = 1'($urandom_range(0, 1));
      wr  = 1'($urandom_range(0, 1));
      wEn = 1'($urandom_range(0, 1));
      k   = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 14));
      runCycle(sel, wr, wEn, k, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
               8'($urandom()));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule